// File: doc/BRIEF.md
# Command-Driven Bus Transfer Master

This block sits between a command decoder and an on-chip bus. It takes one decoded remote-access command at a time. A command names a direction (read or write), a start address, a byte count, and an addressing mode. The block turns it into a series of single-word cycles on a Wishbone-style master port. Write payload arrives one 32-bit word at a time on a valid/ready input stream. Words read from the bus leave on a valid/ready output stream toward the response path.

Two addressing modes exist. Incrementing mode walks a range of memory or registers 4 bytes at a time. Fixed mode keeps hitting one address, which suits FIFO-style ports. Each command is handled on its own. It ends with exactly one completion pulse that carries a status code. A command with an illegal length is refused before any bus activity. A bus error or a missing acknowledge ends the command early.

Top module: `cmd_dma_master`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, and `wb_cyc`, `wb_stb`, `rd_valid`, `wr_ready` and `done_valid` are all 0.
- R2: A command whose byte length is 0, is not a multiple of 4, or exceeds 8192 is refused. In the cycle after acceptance `done_valid` is 1 with `done_status` = 1 (bad length), and no bus cycle is issued.
- R3: In incrementing mode (`cmd_fixed` = 0) the k-th bus cycle of a command, counting from 0, uses address start + 4k.
- R4: In fixed mode (`cmd_fixed` = 1) every bus cycle of the command uses the start address.
- R5: For a write (`cmd_write` = 1) every bus cycle has `wb_we` = 1 and drives the next payload word, in arrival order. No bus cycle starts until its payload word has been taken from the write stream.
- R6: For a read (`cmd_write` = 0) `wb_we` is 0. Each acknowledged word is presented on `rd_data` in bus order. The next bus cycle is not issued until the read stream has accepted the previous word.
- R7: Only one bus cycle is outstanding. `wb_stb` stays high with stable address, write data and `wb_we` until `wb_ack` or `wb_err` is seen, or the timeout fires.
- R8: `wb_err` during a cycle aborts the command. No further bus cycles follow, and the completion carries `done_status` = 2 (bus error).
- R9: If no acknowledge arrives within 256 consecutive cycles of `wb_stb`, the command ends with `done_status` = 3 (timeout). An acknowledge in the 256th cycle still completes normally.
- R10: Each accepted command produces exactly one `done_valid` pulse, one cycle long, after its last word. `done_status` = 0 means success. `cmd_ready` stays low from acceptance until the pulse has ended.
- R11: A length of 8192 bytes is accepted and moves 2048 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_fixed | input | 1 | 1 = fixed address, 0 = incrementing |
| cmd_addr | input | AW (32) | Start byte address |
| cmd_len | input | LEN_W (14) | Transfer length in bytes |
| wr_valid | input | 1 | Write payload word valid |
| wr_ready | output | 1 | Write payload word taken |
| wr_data | input | DW (32) | Write payload word |
| rd_valid | output | 1 | Read word valid |
| rd_ready | input | 1 | Read word accepted downstream |
| rd_data | output | DW (32) | Read word |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | AW (32) | Bus byte address |
| wb_dat_o | output | DW (32) | Bus write data |
| wb_dat_i | input | DW (32) | Bus read data |
| wb_ack | input | 1 | Bus acknowledge |
| wb_err | input | 1 | Bus error |
| done_valid | output | 1 | One-cycle command completion pulse |
| done_status | output | 2 | 0 ok, 1 bad length, 2 bus error, 3 timeout |

## Verification
The bench builds the block with its default parameters: an 8192-byte length limit, a 256-cycle acknowledge window and 32-bit words. With these values the full 2048-word transfer and the exact edge of the timeout window can be reached directly. The bench sends lengths of 8196 and 6 to test both refusal rules. It drives acknowledge delays of 255 and of "never" to hit both sides of the timeout boundary. Stream gaps and read back-pressure show that bus cycle issue stalls behind either stream.

// File: rtl/cmd_dma_pkg.sv
package cmd_dma_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BADLEN  = 2'd1,
    ST_BUSERR  = 2'd2,
    ST_TIMEOUT = 2'd3
  } dma_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_BUS,
    S_PUSH,
    S_DONE
  } dma_state_e;

endpackage

// File: rtl/cmd_len_check.sv
module cmd_len_check #(
  parameter int LEN_W     = 14,
  parameter int MAX_BYTES = 8192,
  parameter int WC_W      = LEN_W - 2
) (
  input  logic [LEN_W-1:0] len,
  output logic             len_ok,
  output logic [WC_W-1:0]  words
);

  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_BYTES);

  always_comb begin
    len_ok = (len != '0) && (len[1:0] == 2'b00) && (len <= LIMIT);
    words  = len[LEN_W-1:2];
  end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic          fixed,
  input  logic          adv,
  output logic [AW-1:0] adr
);

  logic [AW-1:0] adr_q;
  logic          fixed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_q   <= '0;
      fixed_q <= 1'b0;
    end else if (load) begin
      adr_q   <= start;
      fixed_q <= fixed;
    end else if (adv && !fixed_q) begin
      adr_q   <= adr_q + AW'(STEP);
    end
  end

  assign adr = adr_q;

endmodule

// File: rtl/dma_bus_watchdog.sv
module dma_bus_watchdog #(
  parameter int TO_CYCLES = 256,
  parameter int CW        = (TO_CYCLES > 1) ? $clog2(TO_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic expired
);

  localparam logic [CW-1:0] LAST = CW'(TO_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = active && (cnt_q == LAST);

endmodule

// File: rtl/cmd_dma_master.sv
module cmd_dma_master
  import cmd_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LEN_W     = 14,
  parameter int MAX_BYTES = 8192,
  parameter int TO_CYCLES = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic             cmd_fixed,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DW-1:0]    wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [DW-1:0]    rd_data,
  output logic             wb_cyc,
  output logic             wb_stb,
  output logic             wb_we,
  output logic [AW-1:0]    wb_adr,
  output logic [DW-1:0]    wb_dat_o,
  input  logic [DW-1:0]    wb_dat_i,
  input  logic             wb_ack,
  input  logic             wb_err,
  output logic             done_valid,
  output logic [1:0]       done_status
);

  localparam int WC_W = LEN_W - 2;
  localparam int STEP = DW / 8;

  dma_state_e      state_q;
  dma_status_e     status_q;
  logic            we_q;
  logic [WC_W-1:0] left_q;
  logic [DW-1:0]   wdat_q;
  logic [DW-1:0]   rdat_q;

  logic            len_ok;
  logic [WC_W-1:0] len_words;
  logic            accept;
  logic            in_bus;
  logic            timeout_hit;
  logic            beat_ack;

  cmd_len_check #(
    .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES), .WC_W(WC_W)
  ) u_len (
    .len(cmd_len), .len_ok(len_ok), .words(len_words)
  );

  assign accept   = cmd_valid && (state_q == S_IDLE);
  assign in_bus   = (state_q == S_BUS);
  assign beat_ack = in_bus && wb_ack && !wb_err;

  dma_addr_gen #(.AW(AW), .STEP(STEP)) u_addr (
    .clk(clk), .rst(rst),
    .load(accept), .start(cmd_addr), .fixed(cmd_fixed),
    .adv(beat_ack), .adr(wb_adr)
  );

  dma_bus_watchdog #(.TO_CYCLES(TO_CYCLES)) u_wdog (
    .clk(clk), .rst(rst), .active(in_bus), .expired(timeout_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      we_q     <= 1'b0;
      left_q   <= '0;
      wdat_q   <= '0;
      rdat_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (cmd_valid) begin
          we_q   <= cmd_write;
          left_q <= len_words;
          if (!len_ok) begin
            status_q <= ST_BADLEN;
            state_q  <= S_DONE;
          end else begin
            status_q <= ST_OK;
            state_q  <= cmd_write ? S_FETCH : S_BUS;
          end
        end
        S_FETCH: if (wr_valid) begin
          wdat_q  <= wr_data;
          state_q <= S_BUS;
        end
        S_BUS: begin
          if (wb_err) begin
            status_q <= ST_BUSERR;
            state_q  <= S_DONE;
          end else if (wb_ack) begin
            left_q <= left_q - 1'b1;
            if (!we_q) begin
              rdat_q  <= wb_dat_i;
              state_q <= S_PUSH;
            end else if (left_q == WC_W'(1)) begin
              state_q <= S_DONE;
            end else begin
              state_q <= S_FETCH;
            end
          end else if (timeout_hit) begin
            status_q <= ST_TIMEOUT;
            state_q  <= S_DONE;
          end
        end
        S_PUSH: if (rd_ready) begin
          state_q <= (left_q == '0) ? S_DONE : S_BUS;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready   = (state_q == S_IDLE);
  assign wr_ready    = (state_q == S_FETCH);
  assign rd_valid    = (state_q == S_PUSH);
  assign rd_data     = rdat_q;
  assign wb_cyc      = in_bus;
  assign wb_stb      = in_bus;
  assign wb_we       = we_q;
  assign wb_dat_o    = wdat_q;
  assign done_valid  = (state_q == S_DONE);
  assign done_status = status_q;

  // R2: a refused length completes immediately with the bad-length code
  a_r2_reject_badlen: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !len_ok) |=> (done_valid && done_status == 2'd1 && !wb_stb));

  // R5: a missing payload word holds off the bus cycle
  a_r5_wr_stall: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && !wr_valid) |=> !wb_stb);

  // R6: a read word not yet taken holds off the next bus cycle
  a_r6_rd_stall: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> !wb_stb);

  // R7: an unanswered strobe keeps its address and data
  a_r7_hold_cycle: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && !wb_ack && !wb_err && !timeout_hit) |=>
      (wb_stb && $stable(wb_adr) && $stable(wb_dat_o) && $stable(wb_we)));

  // R8: an error ends bus activity
  a_r8_err_abort: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && wb_err) |=> (!wb_stb && done_valid && done_status == 2'd2));

  // R10: completion is a single-cycle pulse followed by readiness
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> (!done_valid && cmd_ready));

endmodule

// File: tb/cmd_dma_master_tb_top.sv
module cmd_dma_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LEN_W = 14;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0, cmd_fixed = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic rd_valid, rd_ready = 1'b1;
  logic [DW-1:0] rd_data;
  logic wb_cyc, wb_stb, wb_we;
  logic [AW-1:0] wb_adr;
  logic [DW-1:0] wb_dat_o;
  logic [DW-1:0] wb_dat_i = '0;
  logic wb_ack = 1'b0, wb_err = 1'b0;
  logic done_valid;
  logic [1:0] done_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_dma_master dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_fixed(cmd_fixed), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack), .wb_err(wb_err),
    .done_valid(done_valid), .done_status(done_status)
  );

  int n_cmp = 0, n_bad = 0;
  int cycles = 0;
  int tick = 0;

  // reference state for the current command
  logic [31:0] exp_base = '0;
  bit exp_fixed = 0, exp_we = 0;
  int beats = 0, stb_cycles = 0, done_cnt = 0;
  logic [1:0] last_status = '0;
  logic [31:0] wq[$];
  logic [31:0] rq[$];

  // slave and stream knobs
  int ack_delay = 0, err_at = -1;
  bit never_ack = 0, gap_en = 0, stall_en = 0;
  int wcnt = 0, widx = 0, wtotal = 0;
  bit took = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wpat(input int i);
    return 32'hC0DE0000 ^ (i * 32'h00010003);
  endfunction

  function automatic logic [31:0] rpat(input logic [31:0] a, input int b);
    return a ^ {b[15:0], 16'h5A5A};
  endfunction

  // cycle-by-cycle model: bus slave, stream source/sink, comparison
  always @(negedge clk) if (!rst) begin
    tick++;
    if (wb_stb) begin
      stb_cycles++;
      check(wb_adr == (exp_fixed ? exp_base : exp_base + 32'(4 * beats)),
            exp_fixed ? "R4" : "R3", "bus address", wb_adr,
            exp_fixed ? exp_base : exp_base + 32'(4 * beats));
      check(wb_we == exp_we, exp_we ? "R5" : "R6", "write enable", wb_we, exp_we);
    end
    if (wb_stb && !wb_ack && !wb_err) begin
      if (!never_ack) begin
        if (wcnt >= ack_delay) begin
          wcnt = 0;
          if (beats == err_at) begin
            wb_err = 1'b1;
          end else begin
            wb_ack = 1'b1;
            if (exp_we) begin
              if (wq.size() == 0) check(0, "R5", "payload before cycle", wb_dat_o, 0);
              else check(wb_dat_o == wq[0], "R5", "write data", wb_dat_o, wq[0]);
              if (wq.size() != 0) void'(wq.pop_front());
            end else begin
              wb_dat_i = rpat(wb_adr, beats);
              rq.push_back(wb_dat_i);
            end
            beats++;
          end
        end else wcnt++;
      end
    end else begin
      wb_ack = 1'b0;
      wb_err = 1'b0;
      wcnt = 0;
    end
    if (took) begin
      wr_valid = 1'b0;
      widx++;
    end
    if (!wr_valid && widx < wtotal && (!gap_en || tick % 3 == 0)) begin
      wr_valid = 1'b1;
      wr_data = wpat(widx);
    end
    took = wr_valid && wr_ready;
    if (took) wq.push_back(wr_data);
    rd_ready = !stall_en || (tick % 4 != 0);
    if (rd_valid && rd_ready) begin
      if (rq.size() == 0) check(0, "R6", "unexpected read word", rd_data, 0);
      else begin
        check(rd_data == rq[0], "R6", "read data", rd_data, rq[0]);
        void'(rq.pop_front());
      end
    end
    if (done_valid) begin
      done_cnt++;
      last_status = done_status;
    end
  end

  task automatic run_cmd(input bit we, input bit fx, input logic [31:0] a,
                         input int len, input int words_to_send,
                         input logic [1:0] exp_st, input int exp_beats,
                         input int exp_stb, input string req);
    int n;
    @(negedge clk); #1;
    exp_base = a; exp_fixed = fx; exp_we = we;
    beats = 0; stb_cycles = 0; done_cnt = 0;
    wq.delete(); rq.delete();
    widx = 0; wtotal = words_to_send; took = 0; wr_valid = 1'b0;
    check(cmd_ready == 1'b1, "R10", "ready before command", cmd_ready, 1);
    cmd_write = we; cmd_fixed = fx; cmd_addr = a; cmd_len = LEN_W'(len);
    cmd_valid = 1'b1;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
    n = 0;
    while (done_cnt == 0 && n < 20000) begin
      if (!done_valid)
        check(cmd_ready == 1'b0, "R10", "ready while busy", cmd_ready, 0);
      @(negedge clk); #1;
      n++;
    end
    check(done_cnt == 1, req, "completion seen", done_cnt, 1);
    check(last_status == exp_st, req, "status", last_status, exp_st);
    check(beats == exp_beats, req, "acknowledged beats", beats, exp_beats);
    if (exp_stb >= 0) check(stb_cycles == exp_stb, req, "strobe cycles", stb_cycles, exp_stb);
    if (!we) check(rq.size() == 0, "R6", "read words left undelivered", rq.size(), 0);
    @(negedge clk); #1;
    check(done_cnt == 1 && !done_valid, "R10", "single done pulse", done_cnt, 1);
    wtotal = 0; wr_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
    check(!wb_cyc && !wb_stb, "R1", "bus idle", {wb_cyc, wb_stb}, 0);
    check(!rd_valid && !wr_ready && !done_valid, "R1", "streams idle",
          {rd_valid, wr_ready, done_valid}, 0);

    // R3 R5: incrementing write with payload gaps
    gap_en = 1;
    run_cmd(1, 0, 32'h0000_1000, 16, 4, 2'd0, 4, 4, "R5");
    gap_en = 0;
    // R3 R6 R7: incrementing read, slow slave, read back-pressure
    ack_delay = 2; stall_en = 1;
    run_cmd(0, 0, 32'h0000_2000, 20, 0, 2'd0, 5, 15, "R7");
    ack_delay = 0; stall_en = 0;
    // R4: fixed-address write and read
    run_cmd(1, 1, 32'h0000_3004, 12, 3, 2'd0, 3, 3, "R4");
    stall_en = 1;
    run_cmd(0, 1, 32'h0000_3008, 16, 0, 2'd0, 4, 4, "R4");
    stall_en = 0;
    // R2: refused lengths
    run_cmd(1, 0, 32'h0000_4000, 0, 0, 2'd1, 0, 0, "R2");
    run_cmd(0, 0, 32'h0000_4000, 6, 0, 2'd1, 0, 0, "R2");
    run_cmd(0, 0, 32'h0000_4000, 8196, 0, 2'd1, 0, 0, "R2");
    // R8: error on third read beat
    err_at = 2;
    run_cmd(0, 0, 32'h0000_5000, 24, 0, 2'd2, 2, 3, "R8");
    err_at = -1;
    // R9: no acknowledge at all, then acknowledge in the last allowed cycle
    never_ack = 1;
    run_cmd(1, 0, 32'h0000_6000, 4, 1, 2'd3, 0, 256, "R9");
    never_ack = 0; ack_delay = 255;
    run_cmd(1, 0, 32'h0000_6000, 4, 1, 2'd0, 1, 256, "R9");
    ack_delay = 0;
    // R11: largest transfer
    run_cmd(1, 0, 32'h0001_0000, 8192, 2048, 2'd0, 2048, 2048, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule